// File: doc/BRIEF.md
# Command Packet Decoder and Executor

This block takes in a command buffer as a stream of 64-bit little-endian chunks, one chunk per valid/ready handshake. Each packet opens with a header chunk. Zero or more payload chunks follow it. The block checks each header and collects the payload. It then runs register-oriented commands against an internal bank of 64-bit registers and a single-beat memory request port. Commands run strictly one at a time and in order.

The block runs five commands itself: end of buffer, set register from immediate, load register from memory, store register to memory, and store immediate to memory. Any other opcode goes out unchanged on a side command port as its header beat followed by its payload beats. The block then waits for a completion strobe from whatever serves that port. A malformed header raises a one-cycle error pulse, and the packet's payload is discarded.

Header layout, with bit positions fixed by the format: bits 7:0 are reserved and must be zero; bits 15:8 hold the opcode; bits 29:16 hold a count equal to twice the number of payload chunks; bits 31:30 hold a tag that must be 2'b11; bits 63:32 hold a 32-bit inline operand whose meaning depends on the opcode.

Top module: `cmdpkt_engine`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, no memory or side request is valid, `buf_done` and `pkt_error` are 0, and all 40 registers (indices 0 to 39) read as zero.
- R2: A header whose tag (bits 31:30) is not 2'b11, whose count (bits 29:16) is odd, or whose reserved bits 7:0 are non-zero raises `pkt_error` for exactly the cycle after the header is accepted. The next floor(count/2) chunks are then consumed with no other effect.
- R3: Opcode 1 (bits 15:8) with count 0 raises `buf_done` for exactly the cycle after the header is accepted.
- R4: Opcode 2 with count 2 writes its single payload chunk into the register whose index is the inline field. An index of 40 or above changes no register.
- R5: Opcode 3 with count 2 issues a read whose address is the payload chunk. The read response data is written into the register named by the inline field.
- R6: Opcode 4 with count 2 issues a write whose address is the payload chunk and whose data is the named register. An index of 40 or above supplies zero.
- R7: Opcode 5 with count 2 issues a write whose address is the 32-bit inline field, zero-extended, and whose data is the payload chunk.
- R8: Opcode 1 with a non-zero count, or opcodes 2 to 5 with a count other than 2, is malformed. It is handled as in R2 and executes nothing.
- R9: Any other well-formed opcode is forwarded on the side port. The header beat comes first with `side_first` set, then each payload beat in order. `side_last` marks the final beat, and the header beat itself when there is no payload.
- R10: No new chunk is accepted while a memory request, a read response or a side completion strobe is still outstanding. Each command therefore finishes before the next header is taken.
- R11: A valid memory request or side beat holds its valid and contents unchanged until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command chunk valid |
| in_data | input | 64 | Command chunk |
| in_ready | output | 1 | Chunk accepted when high with `in_valid` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W (64) | Memory request address |
| mem_req_wdata | output | 64 | Write data |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| side_valid | output | 1 | Forwarded beat valid |
| side_first | output | 1 | Beat is the packet header |
| side_last | output | 1 | Beat is the final one of the packet |
| side_data | output | 64 | Forwarded beat |
| side_ready | input | 1 | Forwarded beat accepted |
| side_done | input | 1 | Forwarded command finished |
| buf_done | output | 1 | One-cycle end-of-buffer pulse |
| pkt_error | output | 1 | One-cycle malformed-header pulse |

## Verification
The test stream mixes every local opcode with register indices at 0, 39 and just beyond the bank. The out-of-range indices are chosen to alias real entries in their low bits, so a truncated index decode shows up. One load is followed at once by a store of the same register, which separates in-order execution from a design that lets the store read the register early. Malformed headers carry payload chunks that are themselves valid end-of-buffer headers, which exposes any failure to discard. Forwarded packets with zero and several payload beats, under toggling ready on both request ports, check beat order, first/last marking and the stall until the completion strobe.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CHUNK_W = 64;
    localparam int OPC_W   = 8;
    localparam int CNT_W   = 14;
    localparam int INL_W   = 32;
    localparam int BEAT_W  = CNT_W - 1;

    typedef logic [CHUNK_W-1:0] chunk_t;

    localparam logic [1:0] PKT_TAG = 2'b11;

    localparam logic [OPC_W-1:0] OPC_END    = 8'd1;
    localparam logic [OPC_W-1:0] OPC_SETREG = 8'd2;
    localparam logic [OPC_W-1:0] OPC_LDREG  = 8'd3;
    localparam logic [OPC_W-1:0] OPC_STREG  = 8'd4;
    localparam logic [OPC_W-1:0] OPC_STIMM  = 8'd5;

    // Packed from the top bit down, so it overlays the 64-bit header chunk.
    typedef struct packed {
        logic [INL_W-1:0] inl;
        logic [1:0]       tag;
        logic [CNT_W-1:0] cnt;
        logic [OPC_W-1:0] opc;
        logic [7:0]       rsvd;
    } hdr_t;

    typedef enum logic [2:0] {
        K_END,
        K_SETREG,
        K_LDREG,
        K_STREG,
        K_STIMM,
        K_SIDE
    } kind_e;

    typedef enum logic [3:0] {
        ST_HDR,
        ST_PAY,
        ST_DROP,
        ST_MEM,
        ST_RSP,
        ST_SIDE_HDR,
        ST_SIDE_PAY,
        ST_SIDE_WAIT
    } state_e;

    function automatic kind_e kind_of(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_END:    return K_END;
            OPC_SETREG: return K_SETREG;
            OPC_LDREG:  return K_LDREG;
            OPC_STREG:  return K_STREG;
            OPC_STIMM:  return K_STIMM;
            default:    return K_SIDE;
        endcase
    endfunction

    // Count field a locally executed command must carry (twice its payload chunks).
    function automatic logic [CNT_W-1:0] local_cnt(input kind_e k);
        return (k == K_END) ? CNT_W'(0) : CNT_W'(2);
    endfunction
endpackage

// File: rtl/cmdpkt_hdr_check.sv
module cmdpkt_hdr_check
    import cmdpkt_pkg::*;
(
    input  chunk_t             raw,
    output hdr_t               hdr,
    output kind_e              kind,
    output logic               malformed,
    output logic [BEAT_W-1:0]  nbeats
);
    timeunit 1ns;
    timeprecision 100ps;

    logic bad_frame;
    logic bad_len;

    always_comb begin
        hdr       = hdr_t'(raw);
        kind      = kind_of(hdr.opc);
        bad_frame = (hdr.tag != PKT_TAG) || hdr.cnt[0] || (hdr.rsvd != 8'h00);
        bad_len   = (kind != K_SIDE) && (hdr.cnt != local_cnt(kind));
        malformed = bad_frame || bad_len;
        nbeats    = hdr.cnt[CNT_W-1:1];
    end
endmodule

// File: rtl/cmdpkt_regfile.sv
module cmdpkt_regfile
    import cmdpkt_pkg::*;
#(
    parameter int NREGS = 40,
    parameter int IDX_W = INL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  chunk_t           wdata,
    input  logic [IDX_W-1:0] ridx,
    output chunk_t           rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    chunk_t             regs [NREGS];
    logic   [NREGS-1:0] hit;

    // Full-width index compare: indices at or past NREGS match no entry.
    for (genvar gi = 0; gi < NREGS; gi++) begin : g_hit
        assign hit[gi] = we && (widx == IDX_W'(gi));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (hit[i]) begin
                regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int j = 0; j < NREGS; j++) begin
            if (ridx == IDX_W'(j)) begin
                rdata = regs[j];
            end
        end
    end
endmodule

// File: rtl/cmdpkt_seq.sv
module cmdpkt_seq
    import cmdpkt_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    // chunk intake
    input  logic              in_valid,
    input  chunk_t            in_data,
    output logic              in_ready,
    // decoded view of in_data
    input  hdr_t              dec_hdr,
    input  kind_e             dec_kind,
    input  logic              dec_bad,
    input  logic [BEAT_W-1:0] dec_nbeats,
    // register bank
    output logic              rf_we,
    output logic [INL_W-1:0]  rf_idx,
    output chunk_t            rf_wdata,
    input  chunk_t            rf_rdata,
    // memory port
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output chunk_t            mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  chunk_t            mem_rsp_data,
    // side port
    output logic              side_valid,
    output logic              side_first,
    output logic              side_last,
    output chunk_t            side_data,
    input  logic              side_ready,
    input  logic              side_done,
    // events
    output logic              buf_done,
    output logic              pkt_error
);
    timeunit 1ns;
    timeprecision 100ps;

    state_e            state;
    hdr_t              hdr_q;
    kind_e             kind_q;
    logic [BEAT_W-1:0] left_q;
    logic              req_write_q;
    logic [ADDR_W-1:0] req_addr_q;
    chunk_t            req_data_q;

    logic in_fire;
    logic side_fire;

    always_comb begin
        case (state)
            ST_HDR, ST_PAY, ST_DROP: in_ready = 1'b1;
            ST_SIDE_PAY:             in_ready = side_ready;
            default:                 in_ready = 1'b0;
        endcase
        in_fire = in_valid && in_ready;

        side_valid = (state == ST_SIDE_HDR) || ((state == ST_SIDE_PAY) && in_valid);
        side_first = (state == ST_SIDE_HDR);
        side_last  = ((state == ST_SIDE_HDR) && (left_q == '0)) ||
                     ((state == ST_SIDE_PAY) && (left_q == BEAT_W'(1)));
        side_data  = (state == ST_SIDE_HDR) ? chunk_t'(hdr_q) : in_data;
        side_fire  = side_valid && side_ready;

        mem_req_valid = (state == ST_MEM);
        mem_req_write = req_write_q;
        mem_req_addr  = req_addr_q;
        mem_req_wdata = req_data_q;

        rf_idx   = hdr_q.inl;
        rf_we    = ((state == ST_PAY) && in_fire && (kind_q == K_SETREG)) ||
                   ((state == ST_RSP) && mem_rsp_valid);
        rf_wdata = (state == ST_RSP) ? mem_rsp_data : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_HDR;
            hdr_q       <= '0;
            kind_q      <= K_END;
            left_q      <= '0;
            req_write_q <= 1'b0;
            req_addr_q  <= '0;
            req_data_q  <= '0;
            buf_done    <= 1'b0;
            pkt_error   <= 1'b0;
        end else begin
            buf_done  <= 1'b0;
            pkt_error <= 1'b0;
            case (state)
                ST_HDR: begin
                    if (in_fire) begin
                        hdr_q  <= dec_hdr;
                        kind_q <= dec_kind;
                        left_q <= dec_nbeats;
                        if (dec_bad) begin
                            pkt_error <= 1'b1;
                            state     <= (dec_nbeats == '0) ? ST_HDR : ST_DROP;
                        end else begin
                            case (dec_kind)
                                K_END:   buf_done <= 1'b1;
                                K_SIDE:  state    <= ST_SIDE_HDR;
                                default: state    <= ST_PAY;
                            endcase
                        end
                    end
                end
                ST_DROP: begin
                    if (in_fire) begin
                        left_q <= left_q - BEAT_W'(1);
                        if (left_q == BEAT_W'(1)) begin
                            state <= ST_HDR;
                        end
                    end
                end
                ST_PAY: begin
                    if (in_fire) begin
                        case (kind_q)
                            K_LDREG: begin
                                req_write_q <= 1'b0;
                                req_addr_q  <= in_data[ADDR_W-1:0];
                                state       <= ST_MEM;
                            end
                            K_STREG: begin
                                req_write_q <= 1'b1;
                                req_addr_q  <= in_data[ADDR_W-1:0];
                                req_data_q  <= rf_rdata;
                                state       <= ST_MEM;
                            end
                            K_STIMM: begin
                                req_write_q <= 1'b1;
                                req_addr_q  <= ADDR_W'(hdr_q.inl);
                                req_data_q  <= in_data;
                                state       <= ST_MEM;
                            end
                            default: state <= ST_HDR;
                        endcase
                    end
                end
                ST_MEM: begin
                    if (mem_req_ready) begin
                        state <= req_write_q ? ST_HDR : ST_RSP;
                    end
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        state <= ST_HDR;
                    end
                end
                ST_SIDE_HDR: begin
                    if (side_fire) begin
                        state <= (left_q == '0) ? ST_SIDE_WAIT : ST_SIDE_PAY;
                    end
                end
                ST_SIDE_PAY: begin
                    if (side_fire) begin
                        left_q <= left_q - BEAT_W'(1);
                        if (left_q == BEAT_W'(1)) begin
                            state <= ST_SIDE_WAIT;
                        end
                    end
                end
                ST_SIDE_WAIT: begin
                    if (side_done) begin
                        state <= ST_HDR;
                    end
                end
                default: state <= ST_HDR;
            endcase
        end
    end
endmodule

// File: rtl/cmdpkt_engine.sv
module cmdpkt_engine
    import cmdpkt_pkg::*;
#(
    parameter int NREGS  = 40,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [63:0]       in_data,
    output logic              in_ready,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              side_valid,
    output logic              side_first,
    output logic              side_last,
    output logic [63:0]       side_data,
    input  logic              side_ready,
    input  logic              side_done,
    output logic              buf_done,
    output logic              pkt_error
);
    timeunit 1ns;
    timeprecision 100ps;

    hdr_t              dec_hdr;
    kind_e             dec_kind;
    logic              dec_bad;
    logic [BEAT_W-1:0] dec_nbeats;

    logic              rf_we;
    logic [INL_W-1:0]  rf_idx;
    chunk_t            rf_wdata;
    chunk_t            rf_rdata;

    cmdpkt_hdr_check u_hdr (
        .raw       (in_data),
        .hdr       (dec_hdr),
        .kind      (dec_kind),
        .malformed (dec_bad),
        .nbeats    (dec_nbeats)
    );

    cmdpkt_regfile #(
        .NREGS (NREGS),
        .IDX_W (INL_W)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .widx  (rf_idx),
        .wdata (rf_wdata),
        .ridx  (rf_idx),
        .rdata (rf_rdata)
    );

    cmdpkt_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .dec_hdr       (dec_hdr),
        .dec_kind      (dec_kind),
        .dec_bad       (dec_bad),
        .dec_nbeats    (dec_nbeats),
        .rf_we         (rf_we),
        .rf_idx        (rf_idx),
        .rf_wdata      (rf_wdata),
        .rf_rdata      (rf_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .side_valid    (side_valid),
        .side_first    (side_first),
        .side_last     (side_last),
        .side_data     (side_data),
        .side_ready    (side_ready),
        .side_done     (side_done),
        .buf_done      (buf_done),
        .pkt_error     (pkt_error)
    );
endmodule

// File: rtl/cmdpkt_checker.sv
module cmdpkt_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [63:0]       mem_req_wdata,
    input logic              mem_req_ready,
    input logic              side_valid,
    input logic              side_first,
    input logic [63:0]       side_data,
    input logic              side_ready,
    input logic              buf_done,
    input logic              pkt_error
);
    timeunit 1ns;
    timeprecision 100ps;

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_write)));

    a_r11_side_hold: assert property (@(posedge clk) disable iff (rst)
        (side_valid && !side_ready) |=> (side_valid && $stable(side_data) && $stable(side_first)));

    a_r10_stall_on_mem: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !in_ready);

    a_r10_single_target: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_valid && side_valid));

    a_r9_header_beat_alone: assert property (@(posedge clk) disable iff (rst)
        (side_valid && side_first) |-> !in_ready);

    a_r2_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(buf_done && pkt_error));
endmodule

bind cmdpkt_engine cmdpkt_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_cmdpkt_engine.sv
module sim_cmdpkt_engine;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_data;
    logic        in_ready;
    logic        mem_req_valid, mem_req_write, mem_req_ready;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        side_valid, side_first, side_last, side_ready, side_done;
    logic [63:0] side_data;
    logic        buf_done, pkt_error;

    always #2.5 clk = ~clk;   // 200 MHz

    cmdpkt_engine u0 (.*);

    typedef struct { bit w; logic [63:0] a; logic [63:0] d; } mreq_t;
    mreq_t       mq[$];
    logic [65:0] sq[$];      // {first, last, data}
    logic [63:0] rm[40];

    int n_tests = 0, n_fail = 0;
    int done_cnt = 0, err_cnt = 0, exp_done = 0, exp_err = 0;
    int r10_bad = 0, cyc = 0, side_cd = 0;
    bit rsp_pend = 0, side_busy = 0, finished = 0;
    logic [63:0] rsp_addr;

    function automatic logic [63:0] mem_val(input logic [63:0] a);
        return {a[31:0], ~a[31:0]} ^ 64'h0F0F_1234_A5A5_0001;
    endfunction

    function automatic logic [63:0] mk(input int op, input int cnt, input logic [31:0] inl);
        return {inl, 2'b11, cnt[13:0], op[7:0], 8'h00};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the handshake edge.
    task automatic send(input logic [63:0] d);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_setreg(input int idx, input logic [63:0] v);
        send(mk(2, 2, idx));
        send(v);
        if (idx < 40) rm[idx] = v;
    endtask

    task automatic t_load(input int idx, input logic [63:0] a);
        mq.push_back('{1'b0, a, 64'h0});
        send(mk(3, 2, idx));
        send(a);
        if (idx < 40) rm[idx] = mem_val(a);
    endtask

    task automatic t_store(input int idx, input logic [63:0] a);
        mq.push_back('{1'b1, a, (idx < 40) ? rm[idx] : 64'h0});
        send(mk(4, 2, idx));
        send(a);
    endtask

    task automatic t_side(input int op, input int n);
        logic [63:0] h;
        h = mk(op, 2 * n, 32'hC0DE_0000 + op);
        sq.push_back({1'b1, n == 0, h});
        for (int i = 0; i < n; i++) sq.push_back({1'b0, i == n - 1, 64'hD00D_0000_0000_0000 + i});
        send(h);
        for (int i = 0; i < n; i++) send(64'hD00D_0000_0000_0000 + i);
    endtask

    task automatic t_bad(input logic [63:0] h, input int n, input string req);
        exp_err++;
        send(h);
        chk(pkt_error === 1'b1, req, "error pulse after bad header", {63'h0, pkt_error}, 64'h1);
        for (int i = 0; i < n; i++) send(mk(1, 0, 0));   // payload looks like an end header
    endtask

    // Responders and per-clock comparison against the expected transaction queues.
    initial begin
        mem_req_ready = 0; side_ready = 0; side_done = 0;
        mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            side_done     = 1'b0;
            if (rsp_pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_val(rsp_addr);
                rsp_pend      = 0;
            end
            if (side_cd > 0) begin
                side_cd--;
                if (side_cd == 0) side_done = 1'b1;
            end
            mem_req_ready = (cyc % 3) != 0;
            side_ready    = (cyc % 2) == 0;
            #1;
            if (!rst) begin
                if ((side_busy || mem_rsp_valid) && in_ready) r10_bad++;
                if (side_done) side_busy = 0;
                if (buf_done) done_cnt++;
                if (pkt_error) err_cnt++;
                if (mem_req_valid && mem_req_ready) begin
                    if (mq.size() == 0) begin
                        chk(0, "R10", "unexpected memory request", mem_req_addr, 64'h0);
                    end else begin
                        mreq_t e;
                        e = mq.pop_front();
                        chk(mem_req_write === e.w, "R5/R6/R7", "request direction", {63'h0, mem_req_write}, {63'h0, e.w});
                        chk(mem_req_addr === e.a, "R5/R6/R7", "request address", mem_req_addr, e.a);
                        if (e.w) chk(mem_req_wdata === e.d, "R6/R7", "write data", mem_req_wdata, e.d);
                    end
                    if (!mem_req_write) begin
                        rsp_pend = 1;
                        rsp_addr = mem_req_addr;
                    end
                end
                if (side_valid && side_ready) begin
                    if (sq.size() == 0) begin
                        chk(0, "R9", "unexpected side beat", side_data, 64'h0);
                    end else begin
                        logic [65:0] s;
                        s = sq.pop_front();
                        chk({side_first, side_last, side_data} === s, "R9", "side beat",
                            {side_first, side_last, side_data[61:0]}, {s[65:64], s[61:0]});
                    end
                    if (side_last) begin
                        side_busy = 1;
                        side_cd   = 3;
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        chk(0, "R10", "watchdog expired", 64'h0, 64'h0);
        summary();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        for (int i = 0; i < 40; i++) rm[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle outputs after reset
        chk(in_ready === 1'b1, "R1", "in_ready after reset", {63'h0, in_ready}, 64'h1);
        chk({mem_req_valid, side_valid, buf_done, pkt_error} === 4'b0, "R1", "idle outputs",
            {60'h0, mem_req_valid, side_valid, buf_done, pkt_error}, 64'h0);
        @(negedge clk);
        // R1: registers clear; R6 store path
        t_store(0, 64'h100);
        t_store(39, 64'h108);
        // R4 / R6: write then read back, including the last entry
        t_setreg(3, 64'h1122_3344_5566_7788);
        t_store(3, 64'h200);
        t_setreg(39, 64'hFEDC_BA98_7654_3210);
        t_store(39, 64'h208);
        t_setreg(8, 64'h0000_0000_0000_0808);
        // R4: index 40 aliases entry 8 in the low bits; must write nothing
        t_setreg(40, 64'hBAD0_BAD0_BAD0_BAD0);
        t_store(8, 64'h210);
        t_store(40, 64'h218);
        // R5 + R10: load then immediately store the same register
        t_load(7, 64'h0000_0001_2345_6780);
        t_store(7, 64'h220);
        // R5: out-of-range load destination is dropped (45 aliases 13)
        t_load(45, 64'h0000_0000_0000_4500);
        t_store(13, 64'h228);
        // R7: inline address is zero-extended
        mq.push_back('{1'b1, 64'h0000_0000_FFFF_FFF0, 64'hCAFE_F00D_0000_0005});
        send(mk(5, 2, 32'hFFFF_FFF0));
        send(64'hCAFE_F00D_0000_0005);
        // R3: end of buffer pulses in the next cycle
        exp_done++;
        send(mk(1, 0, 32'h0));
        chk(buf_done === 1'b1, "R3", "end pulse", {63'h0, buf_done}, 64'h1);
        // R2: bad tag, reserved bits, odd count; payload discarded
        t_bad({32'h0, 2'b10, 14'd4, 8'd2, 8'h00}, 2, "R2");
        t_bad(mk(1, 0, 0) | 64'h01, 0, "R2");
        t_bad(mk(2, 3, 5), 1, "R2");
        // R8: local opcodes with wrong length
        t_bad(mk(2, 4, 3), 2, "R8");
        t_bad(mk(1, 2, 0), 1, "R8");
        t_store(3, 64'h230);
        // R9: forwarded packets, with and without payload
        t_side(7, 3);
        t_side(9, 0);
        t_side(0, 1);
        t_store(39, 64'h238);
        exp_done++;
        send(mk(1, 0, 32'h0));
        repeat (30) @(negedge clk);
        #2;
        chk(done_cnt == exp_done, "R3", "end pulse count", done_cnt, exp_done);
        chk(err_cnt == exp_err, "R2", "error pulse count", err_cnt, exp_err);
        chk(mq.size() == 0, "R5/R6/R7", "memory requests missing", mq.size(), 0);
        chk(sq.size() == 0, "R9", "side beats missing", sq.size(), 0);
        chk(r10_bad == 0, "R10", "intake while command pending", r10_bad, 0);
        summary();
    end
endmodule